// File: doc/BRIEF.md
# Machine-Level Control and Status Register Bank

This block is the register bank that a 64-bit RISC-V hart uses for its machine and supervisor control state. It holds the trap handler state for both levels: vector base, scratch, exception PC, cause and fault value. It also holds the machine status word, the ISA descriptor, the counter-enable masks for the two levels, the address-translation register and the trigger selector. It serves the counter, timer and retired-instruction CSRs from live count inputs supplied by the core.

The pipeline presents one access per cycle through `csr_req_i`, `csr_addr_i` (the standard 12-bit CSR number), `csr_we_i` and `csr_wdata_i`. Read data and an illegal-access flag come back combinationally in the same cycle. A write takes effect at the next rising clock edge. Every write goes through a legal-value filter chosen by the target register. Counter reads are gated by the privilege level on `priv_i`, using the encodings 3 = machine, 1 = supervisor and 0 = user.

Top module: `csr_bank`

## Requirements
- R1: After reset, the registers read as follows. The ISA descriptor (0x301) reads 0x800000000014112D, with bit 2 as the compressed-extension (C) bit. The vendor, architecture, implementation and hart ID registers (0xF11–0xF14, hart ID defaulting to 0) read 0. Both counter-enable masks (0x306 machine, 0x106 supervisor) read 0x7. The trigger selector (0x7A0) reads 1. The status word (0x300) reads 0x0000000A00000000. The trap, scratch and translation registers read 0.
- R2: Counter CSR 0xC00+n (n = 0..31) may be read in machine mode at any time. In supervisor mode the read needs bit n of the machine mask (0x306). In user mode it needs bit n of the supervisor mask (0x106). A refused read returns 0 and raises `csr_bad_o` for that cycle.
- R3: Counter n = 0 returns `cycle_i`, n = 1 returns `time_i`, n = 2 returns `instret_i`, and n = 3..31 return `cycle_i`. Writes to any counter CSR change nothing.
- R4: The mode field of the translation register (0x180, bits 63:60) accepts only 0 (no translation) and 8 (39-bit paging). A write with any other mode keeps the old mode and stores bits 59:0.
- R5: A write of value v to the trigger selector stores v+1, modulo 2^64.
- R6: A write to the ISA descriptor that clears bit 2 while `npc_lo_i` is nonzero keeps the old bit 2. In every other case bit 2 and all the other bits take the written value.
- R7: Status bits 35:34 and 33:32 always read 2. Writes to them are discarded, and all other status bits are written.
- R8: Reads of the exception PCs (0x341, 0x141) return bit 0 as 0. Bit 1 also returns 0 while ISA bit 2 is clear. The stored value is not altered.
- R9: An access to an unimplemented address returns 0, raises `csr_bad_o` and changes no register.
- R10: The trap registers (0x305, 0x340–0x343, 0x105, 0x140–0x143) read back the last value written. The counter-enable masks keep the low 32 bits of a write. The ID registers ignore writes. When `csr_req_i` is low, `csr_rdata_o` and `csr_bad_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv_i | input | 2 | Current privilege level (3 M, 1 S, 0 U) |
| npc_lo_i | input | 3 | Low bits of the next program counter |
| cycle_i | input | 64 | Live cycle count |
| time_i | input | 64 | Live wall-clock count |
| instret_i | input | 64 | Live retired-instruction count |
| csr_req_i | input | 1 | Access valid this cycle |
| csr_we_i | input | 1 | Access is a write |
| csr_addr_i | input | 12 | CSR number |
| csr_wdata_i | input | 64 | Write data |
| csr_rdata_o | output | 64 | Read data (filtered) |
| csr_bad_o | output | 1 | Illegal access this cycle |

## Verification
The hardest state to reach is an exception-PC read with bit 1 masked. To get there, ISA bit 2 must first be cleared, and that write is accepted only when `npc_lo_i` is zero. The stimulus therefore first tries the clear with a misaligned next PC and confirms that the bit survives. It then repeats the clear with an aligned next PC and reads both exception PCs. Finally it restores the bit and reads the PCs again. Refused counter reads need the masks lowered and the privilege switched, so the bench rewrites both masks and sweeps counter numbers at all three levels. A randomized phase then mixes every register class against a behavioural model.

// File: rtl/csr_bank.sv
module csr_bank #(
  parameter logic [63:0] HART_ID = 64'd0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  priv_i,
  input  logic [2:0]  npc_lo_i,
  input  logic [63:0] cycle_i,
  input  logic [63:0] time_i,
  input  logic [63:0] instret_i,
  input  logic        csr_req_i,
  input  logic        csr_we_i,
  input  logic [11:0] csr_addr_i,
  input  logic [63:0] csr_wdata_i,
  output logic [63:0] csr_rdata_o,
  output logic        csr_bad_o
);
  localparam logic [11:0] A_MSTATUS = 12'h300, A_MISA = 12'h301, A_MTVEC = 12'h305,
                          A_MCEN = 12'h306, A_MSCR = 12'h340, A_MEPC = 12'h341,
                          A_MCAUSE = 12'h342, A_MTVAL = 12'h343, A_STVEC = 12'h105,
                          A_SCEN = 12'h106, A_SSCR = 12'h140, A_SEPC = 12'h141,
                          A_SCAUSE = 12'h142, A_STVAL = 12'h143, A_SATP = 12'h180,
                          A_TSEL = 12'h7A0;
  localparam logic [63:0] MISA_RST = 64'h8000_0000_0014_112D;
  localparam logic [63:0] XLEN_FIELDS = 64'h0000_000A_0000_0000;
  localparam logic [63:0] XLEN_MASK = 64'h0000_000F_0000_0000;
  localparam int C_BIT = 2;

  logic [63:0] mstatus, misa, mtvec, mscr, mepc, mcause, mtval;
  logic [63:0] stvec, sscr, sepc, scause, stval, satp, tsel;
  logic [31:0] mcen, scen;

  logic [63:0] rd_raw;
  logic        hit, wr, ctr_ok;
  wire         is_ctr = csr_addr_i[11:5] == 7'b1100000;
  wire [4:0]   ctr_n  = csr_addr_i[4:0];
  wire [63:0]  wd     = csr_wdata_i;

  assign ctr_ok = (priv_i == 2'd3) || (priv_i == 2'd1 ? mcen[ctr_n] : scen[ctr_n]);

  function automatic logic [63:0] epc_view(input logic [63:0] v, input logic c);
    return {v[63:2], v[1] & c, 1'b0};
  endfunction

  always_comb begin
    hit = 1'b1;
    rd_raw = '0;
    if (is_ctr)
      rd_raw = ctr_n == 5'd1 ? time_i : (ctr_n == 5'd2 ? instret_i : cycle_i);
    else
      case (csr_addr_i)
        A_MSTATUS: rd_raw = mstatus;
        A_MISA:    rd_raw = misa;
        A_MTVEC:   rd_raw = mtvec;
        A_MCEN:    rd_raw = {32'd0, mcen};
        A_MSCR:    rd_raw = mscr;
        A_MEPC:    rd_raw = epc_view(mepc, misa[C_BIT]);
        A_MCAUSE:  rd_raw = mcause;
        A_MTVAL:   rd_raw = mtval;
        A_STVEC:   rd_raw = stvec;
        A_SCEN:    rd_raw = {32'd0, scen};
        A_SSCR:    rd_raw = sscr;
        A_SEPC:    rd_raw = epc_view(sepc, misa[C_BIT]);
        A_SCAUSE:  rd_raw = scause;
        A_STVAL:   rd_raw = stval;
        A_SATP:    rd_raw = satp;
        A_TSEL:    rd_raw = tsel;
        12'hF11, 12'hF12, 12'hF13: rd_raw = '0;
        12'hF14:   rd_raw = HART_ID;
        default:   hit = 1'b0;
      endcase
  end

  assign csr_bad_o   = csr_req_i && (!hit || (is_ctr && !ctr_ok));
  assign csr_rdata_o = (csr_req_i && !csr_bad_o) ? rd_raw : '0;
  assign wr          = csr_req_i && csr_we_i && !csr_bad_o;

  wire       satp_ok  = wd[63:60] == 4'd0 || wd[63:60] == 4'd8;
  wire       c_keep   = !wd[C_BIT] && npc_lo_i != 3'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mstatus <= XLEN_FIELDS; misa <= MISA_RST; tsel <= 64'd1;
      mcen <= 32'h7; scen <= 32'h7;
      mtvec <= '0; mscr <= '0; mepc <= '0; mcause <= '0; mtval <= '0;
      stvec <= '0; sscr <= '0; sepc <= '0; scause <= '0; stval <= '0; satp <= '0;
    end else if (wr && !is_ctr) begin
      case (csr_addr_i)
        A_MSTATUS: mstatus <= (wd & ~XLEN_MASK) | XLEN_FIELDS;
        A_MISA:    misa <= c_keep ? {wd[63:C_BIT+1], misa[C_BIT], wd[C_BIT-1:0]} : wd;
        A_MTVEC:   mtvec <= wd;
        A_MCEN:    mcen <= wd[31:0];
        A_MSCR:    mscr <= wd;
        A_MEPC:    mepc <= wd;
        A_MCAUSE:  mcause <= wd;
        A_MTVAL:   mtval <= wd;
        A_STVEC:   stvec <= wd;
        A_SCEN:    scen <= wd[31:0];
        A_SSCR:    sscr <= wd;
        A_SEPC:    sepc <= wd;
        A_SCAUSE:  scause <= wd;
        A_STVAL:   stval <= wd;
        A_SATP:    satp <= {satp_ok ? wd[63:60] : satp[63:60], wd[59:0]};
        A_TSEL:    tsel <= wd + 64'd1;
        default: ;
      endcase
    end
  end

  AST_UNMAPPED_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req_i && !is_ctr && !hit) |-> (csr_bad_o && csr_rdata_o == '0)); // R9
  AST_BAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req_i && csr_bad_o) |=> ($stable(mscr) && $stable(misa) && $stable(satp) && $stable(tsel))); // R9
  AST_MACHINE_CTR_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req_i && is_ctr && priv_i == 2'd3) |-> !csr_bad_o); // R2
  AST_SATP_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (satp[63:60] == 4'd0 || satp[63:60] == 4'd8)); // R4
  AST_TSEL_SKEW: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req_i && csr_we_i && csr_addr_i == A_TSEL) |=> tsel == $past(csr_wdata_i) + 64'd1); // R5
  AST_XLEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req_i && csr_addr_i == A_MSTATUS) |-> csr_rdata_o[35:32] == 4'hA); // R7
  AST_EPC_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req_i && (csr_addr_i == A_MEPC || csr_addr_i == A_SEPC)) |-> !csr_rdata_o[0]); // R8
endmodule

// File: tb/csr_bank_test.sv
module csr_bank_test;
  logic clk = 0, rst_n = 0;
  logic [1:0] priv_i = 3;
  logic [2:0] npc_lo_i = 0;
  logic [63:0] cycle_i = 0, time_i = 0, instret_i = 0, csr_wdata_i = 0;
  logic csr_req_i = 0, csr_we_i = 0;
  logic [11:0] csr_addr_i = 0;
  logic [63:0] csr_rdata_o;
  logic csr_bad_o;
  int checks = 0, failures = 0, stepno = 0;
  logic [63:0] st [int];

  csr_bank uut (.*);

  always #5 clk = ~clk;

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic void mreset();
    st.delete();
    st[12'h300] = 64'h0000_000A_0000_0000; st[12'h301] = 64'h8000_0000_0014_112D;
    st[12'h306] = 7; st[12'h106] = 7; st[12'h7A0] = 1;
    foreach (st[k]) ;
    for (int a = 12'hF11; a <= 12'hF14; a++) st[a] = 0;
    st[12'h305] = 0; st[12'h105] = 0; st[12'h180] = 0;
    for (int a = 0; a < 4; a++) begin st[12'h340 + a] = 0; st[12'h140 + a] = 0; end
  endfunction

  function automatic void mread(input int a, input logic [1:0] pv, output logic [63:0] d, output bit b);
    logic [63:0] msk;
    d = 0; b = 0;
    if (a >= 12'hC00 && a <= 12'hC1F) begin
      int n = a - 12'hC00;
      msk = (pv == 1) ? st[12'h306] : st[12'h106];
      if (pv != 3 && !msk[n]) b = 1;
      else d = (n == 1) ? time_i : (n == 2) ? instret_i : cycle_i;
    end else if (st.exists(a)) begin
      msk = st[12'h301];
      d = st[a];
      if (a == 12'h341 || a == 12'h141) begin d[0] = 0; if (!msk[2]) d[1] = 0; end
    end else b = 1;
  endfunction

  function automatic void mwrite(input int a, input logic [63:0] v, input logic [2:0] np);
    logic [63:0] old;
    if (!st.exists(a) || (a >= 12'hF11 && a <= 12'hF14)) return;
    old = st[a];
    case (a)
      12'h180: st[a] = (v[63:60] == 0 || v[63:60] == 8) ? v : {old[63:60], v[59:0]};
      12'h7A0: st[a] = v + 1;
      12'h301: begin st[a] = v; if (!v[2] && np != 0) st[a][2] = old[2]; end
      12'h300: st[a] = {v[63:36], 4'hA, v[31:0]};
      12'h306, 12'h106: st[a] = {32'd0, v[31:0]};
      default: st[a] = v;
    endcase
  endfunction

  task automatic acc(input bit rq, input bit we, input logic [11:0] a, input logic [63:0] wd,
                     input logic [1:0] pv, input logic [2:0] np, input string tag);
    logic [63:0] ed; bit eb;
    @(negedge clk);
    stepno++;
    csr_req_i = rq; csr_we_i = we; csr_addr_i = a; csr_wdata_i = wd; priv_i = pv; npc_lo_i = np;
    cycle_i = 64'h1000 + stepno * 3; time_i = 64'h5_0000 + stepno; instret_i = 64'h900 + stepno * 2;
    #1;
    ed = 0; eb = 0;
    if (rq) mread(int'(a), pv, ed, eb);
    checks++;
    if (csr_rdata_o !== ed || csr_bad_o !== eb) begin
      failures++;
      $display("FAIL %s addr=%h actual rdata=%h bad=%b expected rdata=%h bad=%b",
               tag, a, csr_rdata_o, csr_bad_o, ed, eb);
    end
    @(posedge clk);
    if (rq && we && !eb) mwrite(int'(a), wd, np);
  endtask

  task automatic rd(input logic [11:0] a, input logic [1:0] pv, input string tag);
    acc(1, 0, a, 0, pv, 0, tag);
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] v, input logic [2:0] np, input string tag);
    acc(1, 1, a, v, 3, np, tag);
  endtask

  initial begin
    logic [11:0] pool [24];
    mreset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1 reset state
    foreach (pool[i]) pool[i] = 0;
    rd(12'h301, 3, "R1"); rd(12'h300, 3, "R1"); rd(12'h306, 3, "R1"); rd(12'h106, 3, "R1");
    rd(12'h7A0, 3, "R1"); rd(12'hF11, 3, "R1"); rd(12'hF12, 3, "R1"); rd(12'hF13, 3, "R1");
    rd(12'hF14, 3, "R1"); rd(12'h180, 3, "R1"); rd(12'h341, 3, "R1");
    acc(0, 0, 12'h301, 0, 3, 0, "R10");
    // R3 counter sources, R2 gating
    for (int n = 0; n < 5; n++) rd(12'hC00 + n, 3, "R3");
    rd(12'hC1F, 3, "R3");
    for (int n = 0; n < 4; n++) begin rd(12'hC00 + n, 1, "R2"); rd(12'hC00 + n, 0, "R2"); end
    wr(12'h306, 64'hFFFF_FFFF_0000_0005, 0, "R10"); rd(12'h306, 3, "R10");
    wr(12'h106, 64'h8, 0, "R2");
    for (int n = 0; n < 4; n++) begin rd(12'hC00 + n, 1, "R2"); rd(12'hC00 + n, 0, "R2"); end
    rd(12'hC1F, 2, "R2");
    wr(12'hC00, 64'hDEAD, 0, "R3"); rd(12'hC00, 3, "R3");
    wr(12'hC03, 64'hBEEF, 0, "R3"); rd(12'hC03, 3, "R3");
    // R4 translation mode filter
    wr(12'h180, 64'h8000_0000_0001_2345, 0, "R4"); rd(12'h180, 3, "R4");
    wr(12'h180, 64'h9000_0000_0006_789A, 0, "R4"); rd(12'h180, 3, "R4");
    wr(12'h180, 64'hF0FF_FFFF_FFFF_FFFF, 0, "R4"); rd(12'h180, 3, "R4");
    wr(12'h180, 64'h0000_0000_0000_0011, 0, "R4"); rd(12'h180, 3, "R4");
    // R5 trigger select skew
    wr(12'h7A0, 64'd5, 0, "R5"); rd(12'h7A0, 3, "R5");
    wr(12'h7A0, '1, 0, "R5"); rd(12'h7A0, 3, "R5");
    // R8 / R6 exception PC masking and C bit
    wr(12'h341, '1, 0, "R8"); wr(12'h141, 64'h1234_5677, 0, "R8");
    rd(12'h341, 3, "R8"); rd(12'h141, 3, "R8");
    wr(12'h301, 64'h8000_0000_0014_1129, 3'd2, "R6"); rd(12'h301, 3, "R6"); rd(12'h341, 3, "R8");
    wr(12'h301, 64'h8000_0000_0014_1129, 3'd4, "R6"); rd(12'h301, 3, "R6");
    wr(12'h301, 64'h8000_0000_0014_1128, 3'd0, "R6"); rd(12'h301, 3, "R6");
    rd(12'h341, 3, "R8"); rd(12'h141, 3, "R8");
    wr(12'h301, 64'h8000_0000_0014_112C, 3'd6, "R6"); rd(12'h301, 3, "R6"); rd(12'h341, 3, "R8");
    // R7 status width fields
    wr(12'h300, '1, 0, "R7"); rd(12'h300, 3, "R7");
    wr(12'h300, 64'h0, 0, "R7"); rd(12'h300, 3, "R7");
    // R9 unmapped
    wr(12'h340, 64'h5555, 0, "R10");
    wr(12'h7FF, 64'hAAAA, 0, "R9"); rd(12'h7FF, 3, "R9"); rd(12'h340, 3, "R9");
    wr(12'h000, 64'h1, 0, "R9"); rd(12'h7A0, 3, "R9");
    wr(12'hF14, 64'h77, 0, "R10"); rd(12'hF14, 3, "R10");
    // R10 random mix
    pool = '{12'h300, 12'h301, 12'h305, 12'h306, 12'h340, 12'h341, 12'h342, 12'h343,
             12'h105, 12'h106, 12'h140, 12'h141, 12'h142, 12'h143, 12'h180, 12'h7A0,
             12'hF11, 12'hF14, 12'hC00, 12'hC01, 12'hC02, 12'hC07, 12'h3FF, 12'h5A5};
    for (int i = 0; i < 400; i++) begin
      logic [11:0] a; logic [1:0] pv;
      a = pool[$urandom_range(0, 23)];
      pv = 2'($urandom_range(0, 3));
      acc($urandom_range(0, 7) != 0, $urandom_range(0, 1) == 1, a,
          {$urandom, $urandom}, (a == 12'h306 || a == 12'h106 || a[11:8] == 4'hC) ? pv : 2'd3,
          3'($urandom_range(0, 7)), "R10");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule